// File: doc/BRIEF.md
# Sixteen-Channel Photomultiplier Reduction Unit

This block takes one digitized sample from each of sixteen photomultiplier channels per clock, together with an arrival time and a hit flag for each channel from external time estimators. Each sample is multiplied by a per-channel gain, and a per-channel pedestal is then removed from it. The corrected charges are reduced over all channels. The reduction produces the total charge, the channel holding the largest charge and its value, and the earliest arrival time among the channels that report a hit. These results are packed into one 48-bit summary word per accepted input, which goes to the next board in the trigger tree.

Alongside the reduction, every accepted raw sample set is written into a circular waveform memory. A trigger pulse freezes this memory so that the samples leading up to the event can be read back one at a time through a plain channel/address port. A release pulse resumes recording.

The input and the output are valid/ready streams. The pipeline advances as a unit. When the output holds a word that is not taken, the whole pipeline stalls and `in_ready` drops in the same cycle. No word is lost or reordered, and the output word stays stable until it is accepted.

Top module: `pmt_reduce16`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1, every gain is 64 (unity), every pedestal is 0, and the waveform memory is recording.
- R2: The corrected charge of a channel is floor(sample*gain/64) minus its pedestal, clamped to 0 when negative and to 1023 when above 1023.
- R3: Bits [13:0] of `out_word` hold the sum of the sixteen corrected charges.
- R4: Bits [27:18] hold the largest corrected charge and bits [17:14] hold its channel index. When several channels share the largest charge, the lowest index is reported.
- R5: Bit [36] is 1 when any channel has its hit flag set. Bits [35:28] then hold the smallest arrival time among the hit channels. With no hit they hold 255. Bits [47:37] are 0.
- R6: With `out_ready` held high, the word for an input accepted at a clock edge becomes valid after the sixth edge from that acceptance, counting the accepting edge. Words leave in input order.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_word` holds still and `in_ready` is 0. Otherwise `in_ready` is 1. Every accepted input yields exactly one output word.
- R8: A cycle with `cfg_we` high writes `cfg_gain` and `cfg_ped` to channel `cfg_ch`. The new values apply to inputs accepted after the write, once the pipeline holds no older input.
- R9: Each accepted input's raw samples are stored. `rd_data` shows, one cycle after `rd_ch`/`rd_addr` are presented, channel `rd_ch` of the input accepted `rd_addr` inputs before the most recent stored one (address 0 is the newest).
- R10: A `wb_freeze` pulse stops storage from the next edge on. Inputs accepted while frozen are not stored, and a further freeze pulse changes nothing. A `wb_release` pulse resumes storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample set valid |
| in_ready | output | 1 | Input accepted when high with in_valid |
| in_sample | input | 160 | Channel i sample at bits [10i+9:10i] |
| in_time | input | 128 | Channel i arrival time at bits [8i+7:8i] |
| in_hit | input | 16 | Channel i hit flag at bit i |
| cfg_we | input | 1 | Calibration write strobe |
| cfg_ch | input | 4 | Channel to calibrate |
| cfg_gain | input | 8 | Gain, 6 fractional bits |
| cfg_ped | input | 10 | Pedestal |
| out_valid | output | 1 | Summary word valid |
| out_ready | input | 1 | Downstream accepts summary word |
| out_word | output | 48 | Packed summary word |
| wb_freeze | input | 1 | Freeze the waveform memory |
| wb_release | input | 1 | Resume waveform recording |
| rd_ch | input | 4 | Readback channel |
| rd_addr | input | 7 | Readback age, 0 = newest |
| rd_data | output | 10 | Readback sample |

## Verification
The bench aims at the clamping corners: a pedestal above every possible product has to give 0, not a wrapped large value, and a gain of 255 on full-scale samples has to saturate at 1023 while the sum still fits 14 bits. It drives equal charges on all channels, where a comparator with the wrong direction on ties would report channel 15 instead of 0. It also drives sets with no hits, where a missing mask would leak a non-hit time into the minimum. Random output back-pressure checks for a pipeline that drops or repeats words when it stalls. The waveform readback after a freeze and a release checks for a memory that kept writing while frozen or lost its write position.

// File: rtl/pmtr_pkg.sv
package pmtr_pkg;
  localparam int CH_N      = 16;
  localparam int SMP_W     = 10;
  localparam int TIME_W    = 8;
  localparam int GAIN_W    = 8;
  localparam int GAIN_FRAC = 6;
  localparam int IDX_W     = $clog2(CH_N);
  localparam int SUM_W     = SMP_W + IDX_W;
  localparam int PROD_W    = SMP_W + GAIN_W - GAIN_FRAC;
  localparam int WORD_W    = 48;
  localparam int RSV_W     = WORD_W - SUM_W - IDX_W - SMP_W - TIME_W - 1;
  localparam logic [TIME_W-1:0] NO_TIME = '1;
  localparam logic [GAIN_W-1:0] UNITY_GAIN = GAIN_W'(1 << GAIN_FRAC);

  typedef struct packed {
    logic [SUM_W-1:0]  sum;
    logic [IDX_W-1:0]  idx;
    logic [SMP_W-1:0]  mx;
    logic [TIME_W-1:0] tmin;
    logic              hit;
  } node_t;

  // lower-index operand a wins ties on charge
  function automatic node_t merge(input node_t a, input node_t b);
    node_t r;
    r.sum = a.sum + b.sum;
    if (a.mx >= b.mx) begin
      r.idx = a.idx;
      r.mx  = a.mx;
    end else begin
      r.idx = b.idx;
      r.mx  = b.mx;
    end
    r.tmin = (a.tmin <= b.tmin) ? a.tmin : b.tmin;
    r.hit  = a.hit | b.hit;
    return r;
  endfunction
endpackage

// File: rtl/pmtr_chan_cal.sv
module pmtr_chan_cal
  import pmtr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic [CH_N*SMP_W-1:0]    in_sample,
  input  logic [CH_N*TIME_W-1:0]   in_time,
  input  logic [CH_N-1:0]          in_hit,
  input  logic                     cfg_we,
  input  logic [IDX_W-1:0]         cfg_ch,
  input  logic [GAIN_W-1:0]        cfg_gain,
  input  logic [SMP_W-1:0]         cfg_ped,
  output node_t                    leaf [CH_N]
);
  localparam logic [SMP_W-1:0] Q_MAX = '1;

  logic [GAIN_W-1:0] gain_r [CH_N];
  logic [SMP_W-1:0]  ped_r  [CH_N];
  logic [PROD_W-1:0] prod_r [CH_N];
  logic [TIME_W-1:0] time_r [CH_N];
  logic [CH_N-1:0]   hit_r;

  function automatic logic [SMP_W-1:0] clampq(input logic [PROD_W-1:0] p,
                                              input logic [SMP_W-1:0] pd);
    logic [PROD_W:0] d;
    d = {1'b0, p} - (PROD_W+1)'(pd);
    if (d[PROD_W])
      return '0;
    else if (d[PROD_W-1:0] > PROD_W'(Q_MAX))
      return Q_MAX;
    else
      return d[SMP_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CH_N; i++) begin
        gain_r[i] <= UNITY_GAIN;
        ped_r[i]  <= '0;
      end
    end else if (cfg_we) begin
      gain_r[cfg_ch] <= cfg_gain;
      ped_r[cfg_ch]  <= cfg_ped;
    end
  end

  // stage 1: gain multiply, drop fractional bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CH_N; i++) begin
        prod_r[i] <= '0;
        time_r[i] <= '0;
      end
      hit_r <= '0;
    end else if (adv) begin
      for (int i = 0; i < CH_N; i++) begin
        prod_r[i] <= PROD_W'((18'(in_sample[i*SMP_W +: SMP_W]) * 18'(gain_r[i])) >> GAIN_FRAC);
        time_r[i] <= in_time[i*TIME_W +: TIME_W];
      end
      hit_r <= in_hit;
    end
  end

  // stage 2: pedestal removal and clamp, build tree leaves
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CH_N; i++) begin
        leaf[i] <= '{sum: '0, idx: IDX_W'(i), mx: '0, tmin: NO_TIME, hit: 1'b0};
      end
    end else if (adv) begin
      for (int i = 0; i < CH_N; i++) begin
        leaf[i].sum  <= SUM_W'(clampq(prod_r[i], ped_r[i]));
        leaf[i].mx   <= clampq(prod_r[i], ped_r[i]);
        leaf[i].idx  <= IDX_W'(i);
        leaf[i].tmin <= hit_r[i] ? time_r[i] : NO_TIME;
        leaf[i].hit  <= hit_r[i];
      end
    end
  end

  // R8
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (gain_r[$past(cfg_ch)] == $past(cfg_gain)) && (ped_r[$past(cfg_ch)] == $past(cfg_ped)));
endmodule

// File: rtl/pmtr_red_tree.sv
module pmtr_red_tree
  import pmtr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adv,
  input  node_t  leaf [CH_N],
  output node_t  root
);
  node_t nw [1:2*CH_N-1];

  for (genvar i = 0; i < CH_N; i++) begin : g_leaf
    assign nw[CH_N+i] = leaf[i];
  end

  // one register per internal node: one pipeline stage per tree level
  for (genvar k = 1; k < CH_N; k++) begin : g_node
    node_t r;
    always_ff @(posedge clk) begin
      if (!rst_n)
        r <= '{sum: '0, idx: '0, mx: '0, tmin: NO_TIME, hit: 1'b0};
      else if (adv)
        r <= merge(nw[2*k], nw[2*k+1]);
    end
    assign nw[k] = r;
  end

  assign root = nw[1];

  // R3
  sum_ge_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    root.sum >= SUM_W'(root.mx));
endmodule

// File: rtl/pmtr_wave_ring.sv
module pmtr_wave_ring
  import pmtr_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int VW   = CH_N * SMP_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [VW-1:0]     wr_data,
  input  logic              frz_i,
  input  logic              rel_i,
  input  logic [IDX_W-1:0]  rd_ch,
  input  logic [AW-1:0]     rd_addr,
  output logic [SMP_W-1:0]  rd_data
);
  logic [VW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wp;
  logic           frozen;
  logic [VW-1:0]  rd_word;

  always_ff @(posedge clk) begin
    if (!rst_n)
      frozen <= 1'b0;
    else if (rel_i)
      frozen <= 1'b0;
    else if (frz_i)
      frozen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      wp <= '0;
    else if (wr_ok && !frozen)
      wp <= wp + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (wr_ok && !frozen)
      mem[wp] <= wr_data;
  end

  assign rd_word = mem[wp - AW'(1) - rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_data <= '0;
    else
      rd_data <= rd_word[rd_ch*SMP_W +: SMP_W];
  end

  // R10
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !rel_i) |=> $stable(wp));
endmodule

// File: rtl/pmt_reduce16.sv
module pmt_reduce16
  import pmtr_pkg::*;
#(
  parameter int RING_DEPTH = 128,
  localparam int AW        = $clog2(RING_DEPTH),
  localparam int STG       = 2 + IDX_W
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [CH_N*SMP_W-1:0]   in_sample,
  input  logic [CH_N*TIME_W-1:0]  in_time,
  input  logic [CH_N-1:0]         in_hit,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_ch,
  input  logic [GAIN_W-1:0]       cfg_gain,
  input  logic [SMP_W-1:0]        cfg_ped,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WORD_W-1:0]       out_word,
  input  logic                    wb_freeze,
  input  logic                    wb_release,
  input  logic [IDX_W-1:0]        rd_ch,
  input  logic [AW-1:0]           rd_addr,
  output logic [SMP_W-1:0]        rd_data
);
  logic [STG-1:0] vld;
  logic           adv;
  node_t          leaf [CH_N];
  node_t          root;

  assign adv      = !vld[STG-1] || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (!rst_n)
      vld <= '0;
    else if (adv)
      vld <= {vld[STG-2:0], in_valid};
  end

  pmtr_chan_cal u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .in_sample (in_sample),
    .in_time   (in_time),
    .in_hit    (in_hit),
    .cfg_we    (cfg_we),
    .cfg_ch    (cfg_ch),
    .cfg_gain  (cfg_gain),
    .cfg_ped   (cfg_ped),
    .leaf      (leaf)
  );

  pmtr_red_tree u_tree (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .leaf  (leaf),
    .root  (root)
  );

  pmtr_wave_ring #(.DEPTH(RING_DEPTH)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ok   (in_valid && adv),
    .wr_data (in_sample),
    .frz_i   (wb_freeze),
    .rel_i   (wb_release),
    .rd_ch   (rd_ch),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign out_valid = vld[STG-1];
  assign out_word  = {RSV_W'(0), root.hit, root.tmin, root.mx, root.idx, root.sum};

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R7
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  // R5
  no_hit_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_word[SUM_W+IDX_W+SMP_W+TIME_W]) |->
      (out_word[SUM_W+IDX_W+SMP_W +: TIME_W] == NO_TIME));
endmodule

// File: tb/tb_pmt_reduce16.sv
module tb_pmt_reduce16;
  import pmtr_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;
  localparam int AW = $clog2(DEPTH);
  localparam int VW = CH_N * SMP_W;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [VW-1:0] in_sample = '0;
  logic [CH_N*TIME_W-1:0] in_time = '0;
  logic [CH_N-1:0] in_hit = '0;
  logic cfg_we = 0;
  logic [IDX_W-1:0] cfg_ch = '0;
  logic [GAIN_W-1:0] cfg_gain = '0;
  logic [SMP_W-1:0] cfg_ped = '0;
  logic out_valid, out_ready = 0;
  logic [WORD_W-1:0] out_word;
  logic wb_freeze = 0, wb_release = 0;
  logic [IDX_W-1:0] rd_ch = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [SMP_W-1:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmt_reduce16 #(.RING_DEPTH(DEPTH)) dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [WORD_W-1:0] expq[$];
  logic [VW-1:0] hist[$];
  logic [GAIN_W-1:0] gm[CH_N];
  logic [SMP_W-1:0] pm[CH_N];
  bit stall_pend = 0, xfer = 0, ring_live = 1;
  logic [WORD_W-1:0] held;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int qref(input int s, input int g, input int p);
    int v = (s * g) / 64 - p;
    if (v < 0) v = 0;
    if (v > 1023) v = 1023;
    return v;
  endfunction

  function automatic logic [WORD_W-1:0] wref(input logic [VW-1:0] s,
      input logic [CH_N*TIME_W-1:0] t, input logic [CH_N-1:0] h);
    int sum = 0, best = -1, bi = 0, tm = 255, q;
    bit any = 0;
    logic [WORD_W-1:0] w = '0;
    for (int i = 0; i < CH_N; i++) begin
      q = qref(int'(s[i*SMP_W +: SMP_W]), int'(gm[i]), int'(pm[i]));
      sum += q;
      if (q > best) begin best = q; bi = i; end
      if (h[i]) begin
        any = 1;
        if (int'(t[i*TIME_W +: TIME_W]) < tm) tm = int'(t[i*TIME_W +: TIME_W]);
      end
    end
    w[13:0] = sum[13:0];
    w[17:14] = bi[3:0];
    w[27:18] = best[9:0];
    w[35:28] = tm[7:0];
    w[36] = any;
    return w;
  endfunction

  task automatic step(input bit iv, input logic [VW-1:0] s, input logic [CH_N*TIME_W-1:0] t,
                      input logic [CH_N-1:0] h, input bit ordy);
    logic [WORD_W-1:0] e;
    @(negedge clk);
    if (stall_pend)
      chk(out_valid && out_word == held, "R7 hold", {15'b0, out_valid, out_word}, {16'h1, held});
    in_valid = iv; in_sample = s; in_time = t; in_hit = h; out_ready = ordy;
    #1;
    chk(in_ready == !(out_valid && !out_ready), "R7 ready", in_ready, !(out_valid && !out_ready));
    xfer = 0;
    if (out_valid && out_ready) begin
      xfer = 1;
      if (expq.size() == 0) chk(0, "R7 extra word", out_word, 0);
      else begin
        e = expq.pop_front();
        chk(out_word == e, "R2 R3 R4 R5 word", out_word, e);
      end
    end
    stall_pend = out_valid && !out_ready;
    held = out_word;
    if (in_valid && in_ready) begin
      expq.push_back(wref(s, t, h));
      if (ring_live) begin
        hist.push_back(s);
        if (hist.size() > 32) void'(hist.pop_front());
      end
    end
  endtask

  task automatic drain();
    repeat (12) step(0, '0, '0, '0, 1);
  endtask

  function automatic logic [VW-1:0] rsamp();
    logic [VW-1:0] v;
    for (int i = 0; i < CH_N; i++) v[i*SMP_W +: SMP_W] = SMP_W'($urandom % 1024);
    return v;
  endfunction

  function automatic logic [CH_N*TIME_W-1:0] rtime();
    logic [CH_N*TIME_W-1:0] v;
    for (int i = 0; i < CH_N; i++) v[i*TIME_W +: TIME_W] = TIME_W'($urandom % 256);
    return v;
  endfunction

  task automatic cfg(input int ch, input int g, input int p);
    @(negedge clk);
    in_valid = 0;
    cfg_we = 1; cfg_ch = IDX_W'(ch); cfg_gain = GAIN_W'(g); cfg_ped = SMP_W'(p);
    gm[ch] = GAIN_W'(g); pm[ch] = SMP_W'(p);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd_chk(input int ch, input int addr, input logic [SMP_W-1:0] exp, input string tag);
    @(negedge clk);
    in_valid = 0; rd_ch = IDX_W'(ch); rd_addr = AW'(addr);
    @(negedge clk);
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic pulse_frz(input bit f, input bit r);
    @(negedge clk);
    in_valid = 0; wb_freeze = f; wb_release = r;
    @(negedge clk);
    wb_freeze = 0; wb_release = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] v, keep;
    logic [CH_N*TIME_W-1:0] tv;
    int lat;
    void'($urandom(32'd7319));
    for (int i = 0; i < CH_N; i++) begin gm[i] = 8'd64; pm[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);

    // R1 R2 unity gain, zero pedestal: charge equals sample; R5 no hits
    for (int i = 0; i < CH_N; i++) v[i*SMP_W +: SMP_W] = SMP_W'(i * 37 + 5);
    step(1, v, '0, '0, 1);
    drain();
    // R4 tie on all channels: lowest index wins
    for (int i = 0; i < CH_N; i++) v[i*SMP_W +: SMP_W] = SMP_W'(500);
    for (int i = 0; i < CH_N; i++) tv[i*TIME_W +: TIME_W] = TIME_W'(200 - i);
    step(1, v, tv, 16'h8421, 1);
    drain();
    chk(expq.size() == 0, "R4 tie word drained", expq.size(), 0);

    // R6 latency
    step(1, rsamp(), rtime(), 16'h0010, 1);
    lat = 0;
    for (int n = 1; n <= 10; n++) begin
      step(0, '0, '0, '0, 1);
      if (xfer && lat == 0) lat = n;
    end
    chk(lat == 6, "R6 latency", lat, 6);

    // R8 calibration, R2 clamp corners
    for (int i = 0; i < CH_N; i++) cfg(i, 255, 0);
    v = '1;
    step(1, v, rtime(), '1, 1);
    drain();
    cfg(5, 128, 1023);
    step(1, v, rtime(), '0, 1);
    drain();
    for (int i = 0; i < CH_N; i++) cfg(i, $urandom % 256, $urandom % 300);
    cfg(9, 40, 1023);

    // random traffic with back-pressure
    for (int n = 0; n < 3000; n++)
      step(($urandom % 10) < 7, rsamp(), rtime(), CH_N'($urandom & $urandom), ($urandom % 10) < 7);
    drain();
    // R7 long stall
    for (int n = 0; n < 12; n++) step(1, rsamp(), rtime(), CH_N'($urandom), 0);
    drain();
    chk(expq.size() == 0, "R7 all words delivered", expq.size(), 0);

    // R9 waveform readback
    for (int n = 0; n < 5; n++) step(1, rsamp(), rtime(), '0, 1);
    drain();
    keep = hist[hist.size()-1];
    rd_chk(7, 0, keep[7*SMP_W +: SMP_W], "R9 newest ch7");
    v = hist[hist.size()-3];
    rd_chk(0, 2, v[0 +: SMP_W], "R9 age2 ch0");
    v = hist[hist.size()-5];
    rd_chk(15, 4, v[15*SMP_W +: SMP_W], "R9 age4 ch15");

    // R10 freeze: later inputs not stored
    pulse_frz(1, 0);
    ring_live = 0;
    for (int n = 0; n < 3; n++) step(1, rsamp(), rtime(), '0, 1);
    drain();
    rd_chk(7, 0, keep[7*SMP_W +: SMP_W], "R10 frozen newest");
    pulse_frz(1, 0);
    step(1, rsamp(), rtime(), '0, 1);
    drain();
    rd_chk(3, 0, keep[3*SMP_W +: SMP_W], "R10 refreeze no effect");
    pulse_frz(0, 1);
    ring_live = 1;
    v = rsamp();
    step(1, v, rtime(), '0, 1);
    drain();
    rd_chk(11, 0, v[11*SMP_W +: SMP_W], "R10 release newest");
    rd_chk(11, 1, keep[11*SMP_W +: SMP_W], "R10 release previous");
    chk(expq.size() == 0, "R7 final drain", expq.size(), 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule